// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, side A and side B, through a pair of capture registers. Each side has its own register and its own clock. Every rising edge of a side's clock loads that side's bus value into its register, whatever the control inputs are doing. An active-low output enable and a direction input decide which bus, if any, the block drives. For each direction, a source select chooses between live data taken straight from the opposite bus and the value held in the opposite side's register.

Each bus pin group is split into an input vector, an output vector and a one-bit drive enable, so the block can be built without tri-state logic. A pad ring or a bench joins the three into a real bus. An asynchronous active-low reset clears both registers, so stored-mode outputs have a defined value after power-up. Each clock domain releases the reset through its own synchronizer.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The A register loads `a_in` on every rising edge of `clk_a`. The B register loads `b_in` on every rising edge of `clk_b`. The two clocks are independent.
- R2: Loading is never gated. A register still captures its bus while `oe_n` is 1, and whatever the values of `dir_a2b` and the two selects.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 (isolation).
- R4: While `oe_n` is 0: if `dir_a2b` is 1, then `b_oe` is 1 and `a_oe` is 0; if `dir_a2b` is 0, then `a_oe` is 1 and `b_oe` is 0.
- R5: `b_out` equals `a_in` when `a2b_stored` is 0 (live mode). It equals the A register when `a2b_stored` is 1 (stored mode).
- R6: `a_out` equals `b_in` when `b2a_stored` is 0. It equals the B register when `b2a_stored` is 1.
- R7: In stored mode with its direction driving, a clock edge on the source side puts the newly captured value on the driven bus before the next edge of that clock.
- R8: The select of the non-driving direction has no effect on the driven bus value. The clock of the non-driving direction also has no effect on it.
- R9: While `rst_n` is 0, both registers read 0, whatever the clocks and buses do. After `rst_n` goes high, each register starts capturing after `SYNC_STAGES` edges of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A register |
| clk_b | input | 1 | Capture clock of the B register |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_a2b | input | 1 | 1: drive the B bus; 0: drive the A bus |
| a2b_stored | input | 1 | Source select for B bus data: 0 live A bus, 1 A register |
| b2a_stored | input | 1 | Source select for A bus data: 0 live B bus, 1 B register |
| a_in | input | W | Value on the A bus pins |
| b_in | input | W | Value on the B bus pins |
| a_out | output | W | Data for the A bus pins |
| a_oe | output | 1 | Drive enable of the A bus pins |
| b_out | output | W | Data for the B bus pins |
| b_oe | output | 1 | Drive enable of the B bus pins |

## Verification
The bench sweeps all sixteen combinations of output enable, direction and the two selects, each under several data patterns. A design that swapped the enable decode, or that let the idle direction's select reach the driven bus, fails this sweep. A register loaded while the outputs are isolated must show its value once stored mode is turned on; a design that gated capture with the enable would show stale data instead. Clock-and-output is checked on both sides of the capture edge, which catches a bus that shows the new value one cycle late or before its edge. The reset check drives all-ones buses while the clocks run, which exposes a register that is not held clear.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Source of the data sent onto a driven bus
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // Drive enables of the two pin groups
  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

  localparam int unsigned SIDE_A = 0;
  localparam int unsigned SIDE_B = 1;
  localparam int unsigned NUM_SIDES = 2;

  function automatic drive_t decode_drive(input logic oe_n, input logic dir_a2b);
    drive_t d;
    d.drive_b = ~oe_n & dir_a2b;
    d.drive_a = ~oe_n & ~dir_a2b;
    return d;
  endfunction

endpackage

// File: rtl/bus_xcvr_rst_sync.sv
module bus_xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bus_xcvr_capture_reg.sv
module bus_xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (cap_en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/bus_xcvr_path_mux.sv
module bus_xcvr_path_mux
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  src_sel_e     sel,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir_a2b,
  input  logic         a2b_stored,
  input  logic         b2a_stored,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  // Capture is never gated by the output controls
  localparam logic CAPTURE_ALWAYS = 1'b1;

  logic [NUM_SIDES-1:0] side_clk;
  logic [NUM_SIDES-1:0] side_rst_n;
  logic [W-1:0]         side_bus   [NUM_SIDES];
  logic [W-1:0]         side_store [NUM_SIDES];
  logic [W-1:0]         side_live  [NUM_SIDES];
  src_sel_e             side_sel   [NUM_SIDES];
  logic [W-1:0]         side_drive [NUM_SIDES];

  // Per-side wiring: index SIDE_A holds the A register and the data sent to A
  assign side_clk[SIDE_A] = clk_a;
  assign side_clk[SIDE_B] = clk_b;
  assign side_bus[SIDE_A] = a_in;
  assign side_bus[SIDE_B] = b_in;

  // Data sent onto side A comes from side B, and the other way round
  assign side_live[SIDE_A] = b_in;
  assign side_live[SIDE_B] = a_in;
  assign side_sel[SIDE_A]  = src_sel_e'(b2a_stored);
  assign side_sel[SIDE_B]  = src_sel_e'(a2b_stored);

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      bus_xcvr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
        .clk        (side_clk[s]),
        .rst_n      (rst_n),
        .rst_n_sync (side_rst_n[s])
      );

      bus_xcvr_capture_reg #(.W(W)) i_store (
        .clk    (side_clk[s]),
        .rst_n  (side_rst_n[s]),
        .cap_en (CAPTURE_ALWAYS),
        .d      (side_bus[s]),
        .q      (side_store[s])
      );

      bus_xcvr_path_mux #(.W(W)) i_mux (
        .live   (side_live[s]),
        .stored (side_store[NUM_SIDES-1-s]),
        .sel    (side_sel[s]),
        .y      (side_drive[s])
      );
    end
  endgenerate

  drive_t drv;
  always_comb drv = decode_drive(oe_n, dir_a2b);

  assign a_out = side_drive[SIDE_A];
  assign b_out = side_drive[SIDE_B];
  assign a_oe  = drv.drive_a;
  assign b_oe  = drv.drive_b;

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic         rst_a_sync_n,
  input logic         rst_b_sync_n,
  input logic         oe_n,
  input logic         dir_a2b,
  input logic         a2b_stored,
  input logic         b2a_stored,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] store_a,
  input logic [W-1:0] store_b
);

  p_isolate_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  p_dir_b_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!oe_n && dir_a2b) |-> (b_oe && !a_oe));

  p_dir_a_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!oe_n && !dir_a2b) |-> (a_oe && !b_oe));

  p_live_a2b_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (b_oe && !a2b_stored) |-> (b_out == a_in));

  p_live_b2a_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (a_oe && !b2a_stored) |-> (a_out == b_in));

  p_capture_a_r1: assert property (@(posedge clk_a) disable iff (!rst_a_sync_n)
    ($past(rst_a_sync_n) && b_oe && a2b_stored) |-> (b_out == $past(a_in)));

  p_capture_b_r1: assert property (@(posedge clk_b) disable iff (!rst_b_sync_n)
    ($past(rst_b_sync_n) && a_oe && b2a_stored) |-> (a_out == $past(b_in)));

  p_reset_clear_r9: assert property (@(posedge clk_a)
    (!rst_n && $past(!rst_n)) |-> (store_a == '0 && store_b == '0));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) i_chk (
  .clk_a        (clk_a),
  .clk_b        (clk_b),
  .rst_n        (rst_n),
  .rst_a_sync_n (side_rst_n[0]),
  .rst_b_sync_n (side_rst_n[1]),
  .oe_n         (oe_n),
  .dir_a2b      (dir_a2b),
  .a2b_stored   (a2b_stored),
  .b2a_stored   (b2a_stored),
  .a_in         (a_in),
  .b_in         (b_in),
  .a_out        (a_out),
  .a_oe         (a_oe),
  .b_out        (b_out),
  .b_oe         (b_oe),
  .store_a      (side_store[0]),
  .store_b      (side_store[1])
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;

  localparam int W = 8;

  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic         rst_n = 1'b1;
  logic         oe_n = 1'b1;
  logic         dir_a2b = 1'b0;
  logic         a2b_stored = 1'b0;
  logic         b2a_stored = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out;
  logic         a_oe;
  logic [W-1:0] b_out;
  logic         b_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // 125 MHz on both clocks, B offset by 1 ns so the domains stay distinct
  always #4 clk_a = ~clk_a;
  initial begin
    #1;
    forever #4 clk_b = ~clk_b;
  end

  bus_xcvr_reg #(.W(W), .SYNC_STAGES(2)) i_bus_xcvr_reg (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .a2b_stored(a2b_stored), .b2a_stored(b2a_stored),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  // Reference registers: load on every edge of their own clock
  logic [W-1:0] m_a, m_b;
  always @(posedge clk_a or negedge rst_n)
    if (!rst_n) m_a <= '0; else m_a <= a_in;
  always @(posedge clk_b or negedge rst_n)
    if (!rst_n) m_b <= '0; else m_b <= b_in;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge of clk_a; sample 2 ns later,
  // clear of the clk_a (+4 ns) and clk_b (+5 ns) rising edges
  task automatic step();
    @(negedge clk_a);
  endtask
  task automatic settle();
    #2;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset with all-ones buses and running clocks
    #1 rst_n = 1'b0;
    a_in = '1; b_in = '1;
    oe_n = 1'b0; dir_a2b = 1'b1; a2b_stored = 1'b1; b2a_stored = 1'b1;
    repeat (3) step();
    settle();
    chk("R9 A register cleared", b_out, '0);
    dir_a2b = 1'b0;
    #1;
    chk("R9 B register cleared", a_out, '0);
    step();
    a_in = '0; b_in = '0;
    rst_n = 1'b1;
    repeat (5) step();

    // R3 R4 R5 R6: sweep every control combination under several patterns
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [W-1:0] pa, pb;
        logic ea, eb;
        pa = W'((p * 8'h37) ^ 8'hA5 ^ c);
        pb = W'((p * 8'h59) + 8'h3C + c);
        step();
        a_in = pa; b_in = pb;
        oe_n = c[3]; dir_a2b = c[2]; a2b_stored = c[1]; b2a_stored = c[0];
        step();
        settle();
        ea = !c[3] && !c[2];
        eb = !c[3] && c[2];
        chk(c[3] ? "R3 a_oe" : "R4 a_oe", W'(a_oe), W'(ea));
        chk(c[3] ? "R3 b_oe" : "R4 b_oe", W'(b_oe), W'(eb));
        if (eb) chk("R5 b_out", b_out, c[1] ? m_a : a_in);
        if (ea) chk("R6 a_out", a_out, c[0] ? m_b : b_in);
      end
    end

    // R2: load while isolated, then show the value in stored mode
    step();
    oe_n = 1'b1; a_in = 8'hC3; b_in = 8'h3C;
    step();
    a_in = 8'h00; b_in = 8'h00;
    oe_n = 1'b0; dir_a2b = 1'b1; a2b_stored = 1'b1;
    settle();
    chk("R2 A loaded while isolated", b_out, 8'hC3);
    dir_a2b = 1'b0; b2a_stored = 1'b1;
    #1;
    chk("R2 B loaded while isolated", a_out, 8'h3C);

    // R7 and R1: clock-and-output, A to B
    step();
    dir_a2b = 1'b1; a2b_stored = 1'b1; a_in = 8'h11;
    step();
    a_in = 8'h5A;
    settle();
    chk("R7 before edge shows old value", b_out, 8'h11);
    step();
    settle();
    chk("R7 R1 after clk_a edge", b_out, 8'h5A);

    // R7 and R1: clock-and-output, B to A
    dir_a2b = 1'b0; b2a_stored = 1'b1; b_in = 8'h22;
    step();
    b_in = 8'hE7;
    settle();
    chk("R7 before clk_b edge", a_out, 8'h22);
    step();
    settle();
    chk("R7 R1 after clk_b edge", a_out, 8'hE7);

    // R8: idle direction's select and clock leave the driven bus alone
    step();
    dir_a2b = 1'b1; a2b_stored = 1'b1; a_in = 8'h96; b_in = 8'h01;
    step();
    b2a_stored = 1'b0; b_in = 8'hFE;
    settle();
    chk("R8 idle select", b_out, 8'h96);
    step();
    b2a_stored = 1'b1; b_in = 8'h7F;
    step();
    settle();
    chk("R8 idle clock", b_out, 8'h96);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule